// File: doc/BRIEF.md
# Fluorescent Display Column Scan Driver

This block refreshes a multiplexed fluorescent dot display one vertical column at a time. For each column it reads a 7-pixel word from an external framebuffer through a synchronous read port. The four odd rows go out on one serial lane and the three even rows on a second lane. Each lane has its own shift clock. Both clocks share a 4-slot pattern, and the even lane has no tick in the last slot. When the shift is complete, the block places the column number on a 7-bit parallel bus and raises a latch strobe for a fixed time. The display board captures on the falling edge of that strobe.

The next column does not start on a timer. The block waits for a short ready pulse from the display board. That pulse is asynchronous, so it passes through a two-flop synchroniser and a rising-edge detector. If no ready pulse arrives within a timeout, the controller moves on anyway and sets a sticky error flag.

The shift half-period, the latch width and the timeout are all counted in system clocks. By default they are derived from the clock frequency: a shift rate near 416 kHz, a latch near 19 µs and a timeout of 200 µs.

Top module: `vfd_column_scanner`

## Requirements
- R1: `odd_data` carries framebuffer bits 0, 2, 4, 6 (rows 1, 3, 5, 7) in that order. One bit is valid at each of exactly four rising edges of `odd_clk` per column.
- R2: `even_data` carries framebuffer bits 1, 3, 5 (rows 2, 4, 6) in that order. It has exactly three rising edges of `even_clk` per column, and these coincide with the first three `odd_clk` ticks. There is no even tick in the fourth slot.
- R3: Each lane clock stays high for exactly HALF_CYC system clocks per tick and idles low. Lane data never changes while its clock is high.
- R4: Each column begins with `fb_rd_en` high for exactly one cycle, with `fb_addr` equal to the column index. The word on `fb_data` in the following cycle is the one serialised.
- R5: After the last tick, `col_sel` holds the column index as a binary number, bit 0 the least significant. `latch_pulse` is then high for exactly LATCH_CYC cycles, and `col_sel` is stable while it is high.
- R6: The first column after reset is 0. Columns increase by one and wrap from NUM_COLS-1 to 0.
- R7: After `latch_pulse` falls, no new read starts until a rising edge on `ready_in` has been seen. A ready pulse that arrives before the latch falls is ignored.
- R8: If no ready edge arrives, the next read starts exactly TIMEOUT_CYC cycles after the latch falls, and `timeout_err` goes high. It stays high until reset, and it is low before any timeout.
- R9: During reset, `odd_clk`, `even_clk`, `latch_pulse`, `timeout_err` and `col_sel` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fb_rd_en | output | 1 | Framebuffer read strobe |
| fb_addr | output | COL_W | Framebuffer column address |
| fb_data | input | 7 | Pixel column; bit 0 is row 1 |
| odd_clk | output | 1 | Odd-row lane shift clock |
| odd_data | output | 1 | Odd-row lane serial data |
| even_clk | output | 1 | Even-row lane shift clock |
| even_data | output | 1 | Even-row lane serial data |
| col_sel | output | COL_W | Column select number |
| latch_pulse | output | 1 | Latch strobe; the receiver captures on its falling edge |
| ready_in | input | 1 | Asynchronous ready pulse from the display board |
| timeout_err | output | 1 | Sticky flag: a ready pulse was missed |

## Verification
The bench sweeps all 128 seven-bit pixel words through a small eight-column configuration. It decodes both lanes at their rising clock edges, so a swapped lane or a reversed bit order shows up as wrong rows, and a missing or extra even tick shows up as a wrong tick count. Ready pulses are delayed by varying gaps, and the bench looks for any premature read. A controller that advanced on a timer, or that counted a stray ready pulse sent during shifting, would start a column early. The timeout path is timed to the exact cycle, and the sticky flag is checked on the column that follows. A wrong window or a flag that clears itself would be reported. Column wrap and the latch width are checked on every column.

// File: rtl/vfd_scan_pkg.sv
// Package: shared constants and the controller state type for the column
// scan driver. Assumes a fixed 7-pixel column split into odd and even rows.
package vfd_scan_pkg;
    localparam int ROWS   = 7;
    localparam int ODD_N  = (ROWS + 1) / 2;
    localparam int EVEN_N = ROWS / 2;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_LOAD,
        ST_SHIFT,
        ST_LATCH,
        ST_WAIT
    } scan_state_t;
endpackage

// File: rtl/vfd_tick_gen.sv
// Module: half-period strobe for the lane clocks. It pulses tick once every
// HALF_CYC cycles. A synchronous clear restarts the count, so the first tick
// comes exactly HALF_CYC cycles after a load. Assumes HALF_CYC >= 1.
module vfd_tick_gen #(
    parameter int HALF_CYC = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == CW'(HALF_CYC - 1));

    // Count system cycles within one half period.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || tick) cnt_q <= '0;
        else                         cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/vfd_ready_sync.sv
// Module: brings the asynchronous ready pulse into the clock domain through
// two flip-flops, then flags its rising edge for one cycle. Assumes the pulse
// is wide enough to be seen by at least one clock edge.
module vfd_ready_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic meta_q, sync_q, last_q;

    // Two-stage synchroniser plus a delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign rise = sync_q & ~last_q;
endmodule

// File: rtl/vfd_lane_serializer.sv
// Module: splits one pixel column into an odd-row lane and an even-row lane,
// then shifts both out in ODD_N slots. Each slot is a low half then a high
// half of the lane clock. Data moves only as a clock falls. The even clock
// skips the slots beyond EVEN_N. Assumes tick is a one-cycle half-period strobe.
module vfd_lane_serializer
    import vfd_scan_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [ROWS-1:0] pix,
    input  logic            tick,
    output logic            odd_clk,
    output logic            odd_data,
    output logic            even_clk,
    output logic            even_data,
    output logic            done
);
    localparam int SW = (ODD_N > 1) ? $clog2(ODD_N) : 1;

    logic [ODD_N-1:0]  odd_bits, odd_sr;
    logic [EVEN_N-1:0] even_bits, even_sr;
    logic [SW-1:0]     slot_q;
    logic              phase_q, busy_q;

    // Route the odd-numbered rows to one lane and the even ones to the other.
    for (genvar g = 0; g < ODD_N; g++) begin : g_odd
        assign odd_bits[g] = pix[2*g];
    end
    for (genvar g = 0; g < EVEN_N; g++) begin : g_even
        assign even_bits[g] = pix[2*g+1];
    end

    assign odd_data  = odd_sr[0];
    assign even_data = even_sr[0];

    // Slot sequencer: raise the clocks on one tick, lower them and shift on the next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            odd_sr   <= '0;
            even_sr  <= '0;
            slot_q   <= '0;
            phase_q  <= 1'b0;
            busy_q   <= 1'b0;
            odd_clk  <= 1'b0;
            even_clk <= 1'b0;
            done     <= 1'b0;
        end else if (load) begin
            odd_sr   <= odd_bits;
            even_sr  <= even_bits;
            slot_q   <= '0;
            phase_q  <= 1'b0;
            busy_q   <= 1'b1;
            odd_clk  <= 1'b0;
            even_clk <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (busy_q && tick) begin
                if (!phase_q) begin
                    odd_clk  <= 1'b1;
                    even_clk <= (32'(slot_q) < EVEN_N);
                    phase_q  <= 1'b1;
                end else begin
                    odd_clk  <= 1'b0;
                    even_clk <= 1'b0;
                    phase_q  <= 1'b0;
                    odd_sr   <= odd_sr >> 1;
                    even_sr  <= even_sr >> 1;
                    if (slot_q == SW'(ODD_N - 1)) begin
                        busy_q <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        slot_q <= slot_q + 1'b1;
                    end
                end
            end
        end
    end

    // R2
    even_inside_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        even_clk |-> odd_clk);
    // R3
    odd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (odd_clk && $past(odd_clk)) |-> $stable(odd_data));
    // R3
    even_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (even_clk && $past(even_clk)) |-> $stable(even_data));
endmodule

// File: rtl/vfd_column_scanner.sv
// Module: top of the column scan driver. It sequences fetch, load, shift,
// latch and wait for each column, counts columns with wrap, times the latch
// strobe and the ready timeout. Assumes a synchronous framebuffer that returns
// data one cycle after fb_rd_en.
module vfd_column_scanner
    import vfd_scan_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int NUM_COLS    = 128,
    parameter int COL_W       = 7,
    parameter int HALF_CYC    = CLK_HZ / 832_000,
    parameter int LATCH_CYC   = (CLK_HZ / 1_000_000) * 19,
    parameter int TIMEOUT_CYC = (CLK_HZ / 1_000_000) * 200
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             fb_rd_en,
    output logic [COL_W-1:0] fb_addr,
    input  logic [ROWS-1:0]  fb_data,
    output logic             odd_clk,
    output logic             odd_data,
    output logic             even_clk,
    output logic             even_data,
    output logic [COL_W-1:0] col_sel,
    output logic             latch_pulse,
    input  logic             ready_in,
    output logic             timeout_err
);
    localparam int LCW = $clog2(LATCH_CYC + 1);
    localparam int TCW = $clog2(TIMEOUT_CYC + 1);

    scan_state_t      state_q;
    logic [COL_W-1:0] col_q;
    logic [LCW-1:0]   lcnt_q;
    logic [TCW-1:0]   wcnt_q;
    logic             load, tick, shift_done, ready_rise;

    assign load     = (state_q == ST_LOAD);
    assign fb_rd_en = (state_q == ST_FETCH);
    assign fb_addr  = col_q;

    vfd_tick_gen #(.HALF_CYC(HALF_CYC)) i_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (load),
        .tick  (tick)
    );

    vfd_ready_sync i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ready_in),
        .rise     (ready_rise)
    );

    vfd_lane_serializer i_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .pix       (fb_data),
        .tick      (tick),
        .odd_clk   (odd_clk),
        .odd_data  (odd_data),
        .even_clk  (even_clk),
        .even_data (even_data),
        .done      (shift_done)
    );

    // Column controller: advances the states, times the latch, waits for ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_FETCH;
            col_q       <= '0;
            col_sel     <= '0;
            latch_pulse <= 1'b0;
            lcnt_q      <= '0;
            wcnt_q      <= '0;
            timeout_err <= 1'b0;
        end else begin
            case (state_q)
                ST_FETCH: state_q <= ST_LOAD;
                ST_LOAD:  state_q <= ST_SHIFT;
                ST_SHIFT: begin
                    if (shift_done) begin
                        col_sel     <= col_q;
                        latch_pulse <= 1'b1;
                        lcnt_q      <= '0;
                        state_q     <= ST_LATCH;
                    end
                end
                ST_LATCH: begin
                    if (lcnt_q == LCW'(LATCH_CYC - 1)) begin
                        latch_pulse <= 1'b0;
                        wcnt_q      <= '0;
                        state_q     <= ST_WAIT;
                    end else begin
                        lcnt_q <= lcnt_q + 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (ready_rise || wcnt_q == TCW'(TIMEOUT_CYC - 1)) begin
                        if (!ready_rise) timeout_err <= 1'b1;
                        col_q   <= (col_q == COL_W'(NUM_COLS - 1)) ? '0 : col_q + 1'b1;
                        state_q <= ST_FETCH;
                    end else begin
                        wcnt_q <= wcnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_FETCH;
            endcase
        end
    end

    // R4
    single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fb_rd_en |=> !fb_rd_en);
    // R6
    col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fb_rd_en |-> (32'(fb_addr) < NUM_COLS));
    // R5
    col_sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_pulse && $past(latch_pulse)) |-> $stable(col_sel));
    // R7
    no_read_in_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_pulse |-> !fb_rd_en);
    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |=> timeout_err);
endmodule

// File: tb/test_vfd_column_scanner.sv
module test_vfd_column_scanner;
    localparam int NCOL = 8;
    localparam int HALF = 3;
    localparam int LAT  = 6;
    localparam int TOUT = 40;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       fb_rd_en;
    logic [6:0] fb_addr;
    logic [6:0] fb_data;
    logic       odd_clk, odd_data, even_clk, even_data;
    logic [6:0] col_sel;
    logic       latch_pulse;
    logic       ready_in;
    logic       timeout_err;
    int         checks = 0;
    int         fails = 0;
    int         rd_n = 0;

    always #10 clk = ~clk;

    vfd_column_scanner #(
        .NUM_COLS(NCOL), .COL_W(7), .HALF_CYC(HALF),
        .LATCH_CYC(LAT), .TIMEOUT_CYC(TOUT)
    ) i_vfd_column_scanner (
        .clk(clk), .rst_n(rst_n), .fb_rd_en(fb_rd_en), .fb_addr(fb_addr),
        .fb_data(fb_data), .odd_clk(odd_clk), .odd_data(odd_data),
        .even_clk(even_clk), .even_data(even_data), .col_sel(col_sel),
        .latch_pulse(latch_pulse), .ready_in(ready_in), .timeout_err(timeout_err)
    );

    function automatic logic [6:0] pat(input int n);
        return 7'((n * 37 + 11) % 128);
    endfunction

    // Framebuffer model: synchronous read, the word depends on the read count.
    always @(posedge clk) begin
        if (rst_n && fb_rd_en) begin
            fb_data <= pat(rd_n);
            rd_n    <= rd_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs one column: waits for the read, decodes both lanes and checks the latch.
    task automatic run_col(input int n, input bit stray, input int gap);
        int w = 0;
        int orise = 0, erise = 0, hw = 0, lw = 0, it = 0;
        bit bad_w = 0, bad_hold = 0, early_rd = 0;
        logic [3:0] obits = '0;
        logic [2:0] ebits = '0;
        logic op = 0, ep = 0, odp = 0, edp = 0, lp = 0;
        logic [6:0] csel = '0;
        logic [6:0] exp_w = pat(n);
        while (!fb_rd_en && w < 60) begin @(negedge clk); w++; end
        chk(w < 60, "R7 read after ready", w, 0);
        chk(fb_addr == 7'(n % NCOL), "R4/R6 address", fb_addr, n % NCOL);
        forever begin
            @(negedge clk);
            it++;
            if (stray) ready_in = (it == 4);
            if (fb_rd_en) early_rd = 1;
            if (odd_clk && !op) begin if (orise < 4) obits[orise] = odd_data; orise++; end
            if (even_clk && !ep) begin
                if (erise < 3) ebits[erise] = even_data;
                erise++;
                if (!odd_clk) bad_w = 1;
            end
            if (odd_clk) hw++;
            if (!odd_clk && op) begin if (hw != HALF) bad_w = 1; hw = 0; end
            if (op && odd_clk && odd_data != odp) bad_hold = 1;
            if (ep && even_clk && even_data != edp) bad_hold = 1;
            if (latch_pulse) begin lw++; csel = col_sel; end
            if (lp && !latch_pulse) break;
            op = odd_clk; ep = even_clk; odp = odd_data; edp = even_data; lp = latch_pulse;
        end
        ready_in = 0;
        chk(orise == 4, "R1 odd tick count", orise, 4);
        chk(obits == {exp_w[6], exp_w[4], exp_w[2], exp_w[0]}, "R1 odd bits",
            obits, {exp_w[6], exp_w[4], exp_w[2], exp_w[0]});
        chk(erise == 3, "R2 even tick count", erise, 3);
        chk(ebits == {exp_w[5], exp_w[3], exp_w[1]}, "R2 even bits",
            ebits, {exp_w[5], exp_w[3], exp_w[1]});
        chk(!bad_w && !bad_hold, "R3 clock width and data hold", bad_w + 2 * bad_hold, 0);
        chk(lw == LAT, "R5 latch width", lw, LAT);
        chk(csel == 7'(n % NCOL), "R5/R6 col_sel", csel, n % NCOL);
        chk(!early_rd, "R4 single read per column", early_rd, 0);
        if (!stray) begin
            for (int k = 0; k < gap; k++) begin
                if (fb_rd_en) early_rd = 1;
                @(negedge clk);
            end
            chk(!early_rd && !fb_rd_en, "R7 no advance without ready", fb_rd_en, 0);
            ready_in = 1;
            @(negedge clk);
            ready_in = 0;
        end
    endtask

    initial begin
        rst_n    = 1'b0;
        ready_in = 1'b0;
        repeat (4) @(negedge clk);
        // R9
        chk(!odd_clk && !even_clk, "R9 lane clocks in reset", {odd_clk, even_clk}, 0);
        chk(!latch_pulse && !timeout_err, "R9 latch/error in reset", {latch_pulse, timeout_err}, 0);
        chk(col_sel == 0, "R9 col_sel in reset", col_sel, 0);
        rst_n = 1'b1;
        for (int n = 0; n < 128; n++) run_col(n, 1'b0, n % 5);
        chk(!timeout_err, "R8 no error before a timeout", timeout_err, 0);
        // A stray ready during shifting must not count; then no ready at all.
        run_col(128, 1'b1, 0);
        begin
            int d = 0;
            while (!fb_rd_en && d < TOUT + 20) begin @(negedge clk); d++; end
            chk(d == TOUT, "R7/R8 timeout window", d, TOUT);
            chk(timeout_err, "R8 error raised", timeout_err, 1);
        end
        run_col(129, 1'b0, 2);
        chk(timeout_err, "R8 error sticky", timeout_err, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule